// File: doc/BRIEF.md
# Toggle-Handshake Elastic Queue

This block sits between two pipeline stages whose link marks each transfer by a change of level on a request wire and on an acknowledge wire. It does not use valid/ready levels. When the sender flips `goIn`, one new word on `dataIn` is offered. The queue stores that word and answers by flipping `ackOut`. On the far side, the queue flips `goOut` to offer its oldest stored word on `dataOut`. The receiver flips `ackIn` once it has taken the word. A rise and a fall mean the same thing: one transaction.

The storage depth is a parameter, with a minimum of 1. The queue absorbs latency jitter between the stages. A fast sender can keep issuing words while a slow receiver lags, until every slot is full. The output register that holds the word on offer adds one cycle of latency. Everything runs in one clock domain, and both handshake wires are plain toggle levels that are sampled on the clock.

Top module: `handshake_queue`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `ackOut` and `goOut` are 0, `dataOut` is 0 and no word is stored.
- R2: When `goIn` differs from `ackOut` and fewer than DEPTH words are stored, the queue stores `dataIn` at the next clock edge and flips `ackOut` at that edge. `ackOut` never changes unless a request was pending.
- R3: While DEPTH words are stored, `ackOut` holds its level and a pending request waits. The stored count never exceeds DEPTH.
- R4: `goOut` flips only at an edge where `goOut` equalled `ackIn` before the edge and at least one word was stored. At that edge `dataOut` takes the oldest stored word.
- R5: `dataOut` changes only at an edge where `goOut` flips. It stays stable all the time `goOut` differs from `ackIn`.
- R6: Words reach the receiver in the exact order in which they were accepted.
- R7: A rising edge and a falling edge on `goIn` or `ackIn` each count as one complete event.
- R8: A store and a forward may happen at the same edge. With a receiver that acknowledges at once and a sender that is never blocked, one word passes per cycle.
- R9: A word that enters an empty queue with the output idle sees `ackOut` flip at the first edge after `goIn` flips, and `goOut` flip at the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| goIn | input | 1 | Sender request toggle; each change offers one word |
| dataIn | input | WIDTH | Sender word, stable while `goIn` differs from `ackOut` |
| ackOut | output | 1 | Acknowledge toggle back to the sender |
| goOut | output | 1 | Request toggle to the receiver |
| dataOut | output | WIDTH | Word on offer to the receiver |
| ackIn | input | 1 | Receiver acknowledge toggle |

## Verification
`ackOut` answers a request at the first clock edge after it arrives. A stored word can flip `goOut` at the next edge after that, so a word crossing an idle queue shows up two edges after `goIn` toggles. The bench drives every input on the falling clock edge. It steps a behavioural queue model on each rising edge with the same input values the design sees, then compares `ackOut`, `goOut` and `dataOut` with the model on the following falling edge. This way every output is sampled half a cycle after the edge that is meant to move it. The directed checks for R9 sample on the falling edges after the first and second rising edges. The checks for full-queue stalling and for throughput count whole cycles from the falling edge on which the stimulus was applied.

// File: rtl/hsq_pkg.sv
package hsq_pkg;
  // Strobes from control to datapath, valid for the current cycle.
  typedef struct packed {
    logic push;  // store dataIn into the tail slot
    logic pop;   // move the head slot into the output register
  } hsq_strobe_t;
endpackage

// File: rtl/hsq_ctrl.sv
module hsq_ctrl
  import hsq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        goIn,
  input  logic        ackIn,
  output logic        ackOut,
  output logic        goOut,
  output hsq_strobe_t strobe
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [CW-1:0] fillQ;
  logic          ackOutQ;
  logic          goOutQ;
  logic          reqPending;
  logic          outIdle;
  logic          hasWord;
  logic          notFull;

  assign reqPending = goIn ^ ackOutQ;
  assign outIdle    = ~(goOutQ ^ ackIn);
  assign hasWord    = (fillQ != '0);
  assign notFull    = (fillQ != FULL_LVL);

  always_comb begin
    strobe.push = reqPending & notFull;
    strobe.pop  = outIdle & hasWord;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fillQ   <= '0;
      ackOutQ <= 1'b0;
      goOutQ  <= 1'b0;
    end else begin
      if (strobe.push) ackOutQ <= ~ackOutQ;
      if (strobe.pop)  goOutQ  <= ~goOutQ;
      case ({strobe.push, strobe.pop})
        2'b10:   fillQ <= fillQ + CW'(1);
        2'b01:   fillQ <= fillQ - CW'(1);
        default: fillQ <= fillQ;
      endcase
    end
  end

  assign ackOut = ackOutQ;
  assign goOut  = goOutQ;

  // R3: stored count bounded by DEPTH
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fillQ <= FULL_LVL);

  // R3: a full queue keeps the sender waiting
  p_hold_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fillQ == FULL_LVL) |=> $stable(ackOutQ));

  // R2: acknowledge only answers a pending request
  p_ack_needs_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ackOutQ) |-> $past(goIn != ackOutQ));

  // R4: new offer only when the previous one was taken
  p_go_needs_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(goOutQ) |-> $past(goOutQ == ackIn));
endmodule

// File: rtl/hsq_datapath.sv
module hsq_datapath
  import hsq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hsq_strobe_t      strobe,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] slotQ [DEPTH];
  logic [AW-1:0]    wrPtrQ;
  logic [AW-1:0]    rdPtrQ;
  logic [WIDTH-1:0] dataOutQ;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slotQ[i] <= '0;
      else if (strobe.push && (wrPtrQ == AW'(i)))
        slotQ[i] <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtrQ   <= '0;
      rdPtrQ   <= '0;
      dataOutQ <= '0;
    end else begin
      if (strobe.push) wrPtrQ <= nextPtr(wrPtrQ);
      if (strobe.pop) begin
        rdPtrQ   <= nextPtr(rdPtrQ);
        dataOutQ <= slotQ[rdPtrQ];
      end
    end
  end

  assign dataOut = dataOutQ;
endmodule

// File: rtl/handshake_queue.sv
module handshake_queue
  import hsq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             goIn,
  input  logic [WIDTH-1:0] dataIn,
  output logic             ackOut,
  output logic             goOut,
  output logic [WIDTH-1:0] dataOut,
  input  logic             ackIn
);
  hsq_strobe_t strobe;

  hsq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .goIn   (goIn),
    .ackIn  (ackIn),
    .ackOut (ackOut),
    .goOut  (goOut),
    .strobe (strobe)
  );

  hsq_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

  // R5: word on offer moves only together with a new go event
  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(goOut) |-> $stable(dataOut));
endmodule

// File: tb/tb_handshake_queue.sv
module tb_handshake_queue;
  localparam int DEPTH = 4;
  localparam int WIDTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic goIn = 1'b0;
  logic ackIn = 1'b0;
  logic [WIDTH-1:0] dataIn = '0;
  logic ackOut, goOut;
  logic [WIDTH-1:0] dataOut;

  int checks = 0;
  int errors = 0;
  int cycle = 0;
  int rxDelay = 0;
  int rxWait = 0;
  int rxCount = 0;
  bit rxOn = 1'b0;

  // behavioural reference model
  bit mAck, mGo;
  int mData;
  int mQ[$];
  int expQ[$];

  handshake_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk(clk), .rst_n(rst_n), .goIn(goIn), .dataIn(dataIn),
    .ackOut(ackOut), .goOut(goOut), .dataOut(dataOut), .ackIn(ackIn)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycle);
    end
  endtask

  always @(posedge clk) begin
    cycle++;
    if (!rst_n) begin
      mAck = 0; mGo = 0; mData = 0; mQ.delete();
    end else begin
      bit doPush, doPop;
      doPush = (goIn != mAck) && (mQ.size() < DEPTH);
      doPop  = (mGo == ackIn) && (mQ.size() > 0);
      if (doPop) begin mData = mQ.pop_front(); mGo = ~mGo; end
      if (doPush) begin mQ.push_back(int'(dataIn)); mAck = ~mAck; end
    end
    if (cycle > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycle, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // compare with model every cycle, half a cycle after the edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(ackOut == mAck, "R2/R3 ackOut", ackOut, mAck);
      check(goOut == mGo, "R4 goOut", goOut, mGo);
      check(int'(dataOut) == mData, "R5 dataOut", dataOut, mData);
    end
  end

  // receiver: acknowledges after rxDelay falling edges
  always @(negedge clk) begin
    if (rst_n && rxOn && (goOut != ackIn)) begin
      if (rxWait >= rxDelay) begin
        int e;
        e = (expQ.size() > 0) ? expQ.pop_front() : -1;
        check(int'(dataOut) == e, "R6 order", dataOut, e);
        rxCount++;
        ackIn = ~ackIn;
        rxWait = 0;
      end else rxWait++;
    end
  end

  task automatic sendWord(input logic [WIDTH-1:0] d);
    @(negedge clk);
    while (goIn != ackOut) @(negedge clk);
    dataIn = d;
    goIn = ~goIn;
    expQ.push_back(int'(d));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ackOut == 0 && goOut == 0, "R1 reset toggles", {ackOut, goOut}, 0);
    check(dataOut == 0, "R1 reset data", dataOut, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ackOut == 0 && goOut == 0 && dataOut == 0, "R1 after release", {ackOut, goOut}, 0);

    // R9 latency: receiver off, empty queue
    rxOn = 0;
    dataIn = 8'hA5; goIn = 1'b1; expQ.push_back(8'hA5);
    @(negedge clk);
    check(ackOut == 1 && goOut == 0, "R9 first edge", {ackOut, goOut}, 2'b10);
    @(negedge clk);
    check(goOut == 1 && dataOut == 8'hA5, "R9 second edge", dataOut, 8'hA5);
    // R7: falling edge on goIn is one event
    dataIn = 8'h3C; goIn = 1'b0; expQ.push_back(8'h3C);
    @(negedge clk);
    check(ackOut == 0, "R7 falling go accepted", ackOut, 0);
    // R5: output stays on first word while unacknowledged
    repeat (3) @(negedge clk);
    check(dataOut == 8'hA5 && goOut == 1, "R5 hold while outstanding", dataOut, 8'hA5);
    rxDelay = 0; rxOn = 1;
    repeat (4) @(negedge clk);
    check(rxCount == 2 && goOut == ackIn, "R7 both ack edges", rxCount, 2);

    // R3: slow receiver, sender blocked when full
    rxDelay = 40;
    fork
      for (int i = 0; i < 8; i++) sendWord(WIDTH'(8'h10 + i));
    join_none
    repeat (20) @(negedge clk);
    check(goIn != ackOut, "R3 request withheld when full", ackOut, ~goIn);
    begin
      logic a0; a0 = ackOut;
      repeat (10) @(negedge clk);
      check(ackOut == a0, "R3 ackOut stable while full", ackOut, a0);
    end
    wait fork;
    while (expQ.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);

    // R8: streaming, one word per cycle
    rxDelay = 0;
    begin
      int c0, n0;
      c0 = cycle; n0 = rxCount;
      for (int i = 0; i < 20; i++) sendWord(WIDTH'(8'h80 + 3 * i));
      while (rxCount < n0 + 20) @(negedge clk);
      check((cycle - c0) <= 24, "R8 throughput cycles", cycle - c0, 24);
    end

    // R6: varied receiver pacing
    for (int k = 1; k < 4; k++) begin
      rxDelay = k;
      for (int i = 0; i < 10; i++) sendWord(WIDTH'(k * 37 + i * 11));
    end
    while (expQ.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(goOut == ackIn && ackOut == goIn, "R6 drained", goOut, ackIn);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule